// File: doc/BRIEF.md
# Processor Reset and Startup Sequencer

This block decides when a processor core may start after reset. While the reset input is high, it holds instruction execution and bus activity off. It also forces the upper address lines high and clears the self-test status. The reset input can rise at any moment. Its release passes through a two-flop synchronizer, and the logic behind the synchronizer runs synchronously.

On release, the level of the coprocessor-busy input picks the path. If busy is low, an optional self-test phase runs first. That phase ends on a done strobe from the external self-test logic, or after a bounded timeout. Whichever path is taken, a startup wait of a parameterised length (kept between 350 and 450 clocks) follows before execution and the bus are enabled.

The upper-address force flag starts high. It stays high after execution starts, so that the first code fetches land at the top of memory. The first far transfer (an intersegment jump or call) clears it. Only a new reset sets it again.

Top module: `cpu_startup_seq`

## Requirements
Edge numbering: edge 0 is the first rising clock edge that samples `rst_in` low after reset, edge 1 the next, and so on.
- R1: While `rst_in` is high, `exec_en` and `bus_en` are 0, `addr_hi_force` is 1 and `st_pass` is 0. These values take hold as soon as `rst_in` rises, with no clock edge needed.
- R2: `busy_in` is sampled at edge 1 (the last edge of the synchronized reset). A 0 there selects the self-test phase. A 1 skips it.
- R3: When self-test is skipped, `exec_en` is first 1 after edge STARTUP_DLY+1 and is 0 after every earlier edge.
- R4: In the self-test phase, a `st_done` sampled high at edge k (k >= 2) ends the phase. `exec_en` is then first 1 after edge k+STARTUP_DLY.
- R5: When `st_done` ends the self-test, `st_pass` becomes 1 if `st_result` is all zeros and 0 otherwise. The value then holds until the next reset.
- R6: If no `st_done` arrives, the self-test phase ends at edge SELFTEST_LEN+1 with `st_pass` = 0. `exec_en` is then first 1 after edge SELFTEST_LEN+STARTUP_DLY+1.
- R7: `st_done` has no effect outside the self-test phase. It does not change `st_pass` and does not shift the start edge.
- R8: A STARTUP_DLY below 350 is used as 350, and one above 450 is used as 450.
- R9: `bus_en` equals `exec_en` at all times. Once `exec_en` is 1, it stays 1 until reset.
- R10: `addr_hi_force` becomes 0 after the first edge that samples `far_xfer` and `exec_en` both high. It stays 0 until reset. A `far_xfer` sampled while `exec_en` is 0 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_in | input | 1 | Active-high reset; asserts asynchronously, released through the synchronizer |
| busy_in | input | 1 | Coprocessor busy level; low at reset release selects self-test |
| st_done | input | 1 | Single-cycle strobe from the self-test logic marking completion |
| st_result | input | RESULT_W | Self-test result word, valid with `st_done`; zero means pass |
| far_xfer | input | 1 | Strobe for an executed intersegment jump or call |
| exec_en | output | 1 | Instruction execution allowed |
| bus_en | output | 1 | Bus cycles allowed |
| addr_hi_force | output | 1 | Forces address lines 23..20 high for code fetches |
| st_pass | output | 1 | Self-test ran and reported an all-zero result |

## Verification
The properties assume that `rst_in` is high at every clock edge inside a reset pulse. They also assume that `busy_in` is steady across the release, and that `st_done` and `far_xfer` are clean one-cycle pulses driven between edges. The bench changes every input only at falling edges, or in the one async-reset test, mid-cycle with `rst_in` held high over the next edge. It holds `busy_in` constant for a whole reset-and-release sequence. The pass-status property assumes that `st_result` is valid in the cycle that carries `st_done`.

// File: rtl/rsq_pkg.sv
`timescale 1ns/1ps
package rsq_pkg;

  localparam int DLY_MIN = 350;
  localparam int DLY_MAX = 450;

  typedef enum logic [1:0] {
    PH_TEST = 2'd0,
    PH_WAIT = 2'd1,
    PH_RUN  = 2'd2
  } phase_t;

  function automatic int clamp_dly(input int d);
    if (d < DLY_MIN) return DLY_MIN;
    if (d > DLY_MAX) return DLY_MAX;
    return d;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/rsq_rst_sync.sv
`timescale 1ns/1ps
module rsq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst,
  output logic rst_out
);
  localparam int N = (STAGES < 2) ? 2 : STAGES;

  logic [N-1:0] chain;

  // asserts immediately, leaves reset only after N clean edges
  always_ff @(posedge clk or posedge arst) begin
    if (arst) chain <= '1;
    else      chain <= {chain[N-2:0], 1'b0};
  end

  assign rst_out = chain[N-1];
endmodule

// File: rtl/rsq_phase_ctr.sv
`timescale 1ns/1ps
module rsq_phase_ctr #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         clr,
  input  logic         en,
  output logic [W-1:0] val
);
  always_ff @(posedge clk) begin
    if (clr)     val <= '0;
    else if (en) val <= val + 1'b1;
  end
endmodule

// File: rtl/rsq_addr_hold.sv
`timescale 1ns/1ps
module rsq_addr_hold (
  input  logic clk,
  input  logic rst,
  input  logic running,
  input  logic far_xfer,
  output logic force_hi
);
  // set by reset only; first far transfer while running clears it
  always_ff @(posedge clk or posedge rst) begin
    if (rst)                       force_hi <= 1'b1;
    else if (running && far_xfer)  force_hi <= 1'b0;
  end
endmodule

// File: rtl/cpu_startup_seq.sv
`timescale 1ns/1ps
module cpu_startup_seq
  import rsq_pkg::*;
#(
  parameter int STARTUP_DLY  = 400,
  parameter int SELFTEST_LEN = 256,
  parameter int RESULT_W     = 16,
  parameter int SYNC_STAGES  = 2
) (
  input  logic                clk,
  input  logic                rst_in,
  input  logic                busy_in,
  input  logic                st_done,
  input  logic [RESULT_W-1:0] st_result,
  input  logic                far_xfer,
  output logic                exec_en,
  output logic                bus_en,
  output logic                addr_hi_force,
  output logic                st_pass
);
  localparam int DLY_USE = clamp_dly(STARTUP_DLY);
  localparam int ST_USE  = (SELFTEST_LEN < 1) ? 1 : SELFTEST_LEN;
  localparam int CNT_MAX = max2(DLY_USE, ST_USE);
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] DLY_LAST = CNT_W'(DLY_USE - 1);
  localparam logic [CNT_W-1:0] ST_LAST  = CNT_W'(ST_USE - 1);

  logic             rst_int;
  phase_t           phase_q, phase_d;
  logic             ctr_clr;
  logic [CNT_W-1:0] ctr_val;
  logic             pass_d;

  rsq_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .arst    (rst_in),
    .rst_out (rst_int)
  );

  rsq_phase_ctr #(.W(CNT_W)) u_ctr (
    .clk (clk),
    .clr (ctr_clr),
    .en  (phase_q != PH_RUN),
    .val (ctr_val)
  );

  // phase selection: during internal reset the busy level chooses the
  // first phase, so the choice is fixed at the last reset edge
  always_comb begin
    phase_d = phase_q;
    ctr_clr = 1'b0;
    pass_d  = st_pass;
    if (rst_int) begin
      phase_d = busy_in ? PH_WAIT : PH_TEST;
      ctr_clr = 1'b1;
      pass_d  = 1'b0;
    end else begin
      case (phase_q)
        PH_TEST: begin
          if (st_done) begin
            pass_d  = (st_result == '0);
            phase_d = PH_WAIT;
            ctr_clr = 1'b1;
          end else if (ctr_val == ST_LAST) begin
            pass_d  = 1'b0;
            phase_d = PH_WAIT;
            ctr_clr = 1'b1;
          end
        end
        PH_WAIT: begin
          if (ctr_val == DLY_LAST) begin
            phase_d = PH_RUN;
            ctr_clr = 1'b1;
          end
        end
        PH_RUN:  phase_d = PH_RUN;
        default: phase_d = PH_WAIT;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    phase_q <= phase_d;
  end

  // registered outputs, cleared at once by the asynchronous reset edge
  always_ff @(posedge clk or posedge rst_int) begin
    if (rst_int) begin
      exec_en <= 1'b0;
      bus_en  <= 1'b0;
      st_pass <= 1'b0;
    end else begin
      exec_en <= (phase_d == PH_RUN);
      bus_en  <= (phase_d == PH_RUN);
      st_pass <= pass_d;
    end
  end

  rsq_addr_hold u_hold (
    .clk      (clk),
    .rst      (rst_int),
    .running  (exec_en),
    .far_xfer (far_xfer),
    .force_hi (addr_hi_force)
  );
endmodule

// File: rtl/cpu_startup_seq_chk.sv
`timescale 1ns/1ps
module cpu_startup_seq_chk #(
  parameter int RESULT_W = 16
) (
  input logic                clk,
  input logic                rst_in,
  input logic                st_done,
  input logic [RESULT_W-1:0] st_result,
  input logic                far_xfer,
  input logic                exec_en,
  input logic                bus_en,
  input logic                addr_hi_force,
  input logic                st_pass
);
  // R1: reset holds everything quiet
  p_reset_quiet_r1: assert property (@(posedge clk)
    rst_in |-> (!exec_en && !bus_en && addr_hi_force && !st_pass));

  // R9: bus and execution enables agree
  p_bus_match_r9: assert property (@(posedge clk) disable iff (rst_in)
    exec_en == bus_en);

  // R9: execution, once granted, is kept
  p_exec_hold_r9: assert property (@(posedge clk) disable iff (rst_in)
    exec_en |=> exec_en);

  // R5: pass status only rises on a done strobe carrying a zero result
  p_pass_src_r5: assert property (@(posedge clk) disable iff (rst_in)
    $rose(st_pass) |-> ($past(st_done) && ($past(st_result) == '0)));

  // R10: far transfer while running drops the force flag
  p_force_clear_r10: assert property (@(posedge clk) disable iff (rst_in)
    (exec_en && far_xfer && addr_hi_force) |=> !addr_hi_force);

  // R10: once dropped, the force flag stays low
  p_force_sticky_r10: assert property (@(posedge clk) disable iff (rst_in)
    !addr_hi_force |=> !addr_hi_force);

  // R10: before execution starts the flag is still high
  p_force_before_run_r10: assert property (@(posedge clk) disable iff (rst_in)
    !exec_en |-> addr_hi_force);
endmodule

bind cpu_startup_seq cpu_startup_seq_chk #(.RESULT_W(RESULT_W)) u_chk (
  .clk           (clk),
  .rst_in        (rst_in),
  .st_done       (st_done),
  .st_result     (st_result),
  .far_xfer      (far_xfer),
  .exec_en       (exec_en),
  .bus_en        (bus_en),
  .addr_hi_force (addr_hi_force),
  .st_pass       (st_pass)
);

// File: tb/cpu_startup_seq_bench.sv
`timescale 1ns/1ps
module cpu_startup_seq_bench;
  localparam int DLY    = 400;
  localparam int STLEN  = 256;
  localparam int RW     = 16;
  localparam int LO_DLY = 350;   // clamped value of the second instance

  logic clk = 1'b0;
  logic rst_in = 1'b0;
  logic busy_in = 1'b1;
  logic st_done = 1'b0;
  logic [RW-1:0] st_result = '0;
  logic far_xfer = 1'b0;
  logic exec_en, bus_en, addr_hi_force, st_pass;
  logic exec_lo, bus_lo, force_lo, pass_lo;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  cpu_startup_seq #(.STARTUP_DLY(DLY), .SELFTEST_LEN(STLEN), .RESULT_W(RW))
  u_cpu_startup_seq (
    .clk(clk), .rst_in(rst_in), .busy_in(busy_in), .st_done(st_done),
    .st_result(st_result), .far_xfer(far_xfer), .exec_en(exec_en),
    .bus_en(bus_en), .addr_hi_force(addr_hi_force), .st_pass(st_pass)
  );

  // out-of-range delay, expected to behave as 350
  cpu_startup_seq #(.STARTUP_DLY(100), .SELFTEST_LEN(STLEN), .RESULT_W(RW))
  u_cpu_startup_seq_lo (
    .clk(clk), .rst_in(rst_in), .busy_in(busy_in), .st_done(st_done),
    .st_result(st_result), .far_xfer(far_xfer), .exec_en(exec_lo),
    .bus_en(bus_lo), .addr_hi_force(force_lo), .st_pass(pass_lo)
  );

  typedef struct packed {
    logic        busy;
    logic        give;
    logic [15:0] dcyc;
    logic [15:0] res;
    logic        exp_pass;
    logic [15:0] exp_first;
  } row_t;

  // exp_first: edge index after which exec_en is first high
  localparam row_t ROWS [5] = '{
    '{1'b1, 1'b0, 16'd0,  16'h0000, 1'b0, 16'(DLY + 1)},          // skip test
    '{1'b0, 1'b1, 16'd5,  16'h0000, 1'b1, 16'(5 + DLY)},          // pass
    '{1'b0, 1'b1, 16'd10, 16'h0400, 1'b0, 16'(10 + DLY)},         // fail
    '{1'b0, 1'b0, 16'd0,  16'h0000, 1'b0, 16'(STLEN + DLY + 1)},  // timeout
    '{1'b1, 1'b1, 16'd5,  16'h0000, 1'b0, 16'(DLY + 1)}           // stray done
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic busy);
    @(negedge clk);
    rst_in  = 1'b1;
    busy_in = busy;
    st_done = 1'b0;
    far_xfer = 1'b0;
    repeat (3) @(negedge clk);
    rst_in = 1'b0;   // edge 0 follows
  endtask

  task automatic run_edges(input logic give, input int dcyc, input logic [RW-1:0] res,
                           input int far_at, output int first, output int first_lo);
    first = -1;
    first_lo = -1;
    for (int i = 0; i < 1200; i++) begin
      st_done   = give && (i == dcyc);
      st_result = res;
      far_xfer  = (i == far_at);
      @(posedge clk);
      @(negedge clk);
      if (exec_lo && first_lo < 0) first_lo = i;
      if (exec_en && first < 0) begin
        first = i;
        break;
      end
    end
    st_done = 1'b0;
    far_xfer = 1'b0;
  endtask

  initial begin
    #4_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int f, flo;
    #1 rst_in = 1'b1;

    // R1: state during reset
    @(negedge clk); @(negedge clk);
    check("R1 exec_en in reset", int'(exec_en), 0);
    check("R1 bus_en in reset", int'(bus_en), 0);
    check("R1 addr_hi_force in reset", int'(addr_hi_force), 1);
    check("R1 st_pass in reset", int'(st_pass), 0);

    // table: R2 R3 R4 R5 R6 R7 R8 R9
    for (int r = 0; r < 5; r++) begin
      do_reset(ROWS[r].busy);
      run_edges(ROWS[r].give, int'(ROWS[r].dcyc), ROWS[r].res, -1, f, flo);
      check($sformatf("R2/R3/R4/R6 start edge row %0d", r), f, int'(ROWS[r].exp_first));
      check($sformatf("R8 clamped start edge row %0d", r), flo,
            int'(ROWS[r].exp_first) - (DLY - LO_DLY));
      check($sformatf("R5/R7 st_pass row %0d", r), int'(st_pass), int'(ROWS[r].exp_pass));
      check($sformatf("R9 bus_en row %0d", r), int'(bus_en), 1);
      repeat (3) @(negedge clk);
      check($sformatf("R9 exec_en kept row %0d", r), int'(exec_en), 1);
      check($sformatf("R5 st_pass held row %0d", r), int'(st_pass), int'(ROWS[r].exp_pass));
    end

    // R10: far transfer before execution is ignored, first one after clears
    do_reset(1'b1);
    run_edges(1'b0, -1, '0, 5, f, flo);
    check("R10 force kept after early far_xfer", int'(addr_hi_force), 1);
    far_xfer = 1'b1;
    @(posedge clk); @(negedge clk);
    far_xfer = 1'b0;
    check("R10 force cleared by far_xfer", int'(addr_hi_force), 0);
    repeat (5) @(negedge clk);
    check("R10 force stays low", int'(addr_hi_force), 0);

    // R1: asynchronous effect mid-cycle while running
    #5 rst_in = 1'b1;
    #1;
    check("R1 async exec_en", int'(exec_en), 0);
    check("R1 async bus_en", int'(bus_en), 0);
    check("R1 async addr_hi_force", int'(addr_hi_force), 1);
    @(negedge clk);
    rst_in = 1'b0;
    repeat (2) @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule